// File: doc/BRIEF.md
# Multi-Context Packet Statistics Engine

This block keeps traffic statistics for many packet classes at once. It has one shared update datapath and a bank of per-class statistic records. Every packet arrives with three things: a class index taken from the classification result, its length and its arrival time. The engine updates the record of that class with six values: the packet count, the byte total, the smallest length, the largest length, the last arrival time and the sum of the gaps between arrivals. Software computes mean length and mean gap from these sums and the count.

Records live in a RAM. Each operation makes two passes through a short pipeline: the record is read in the first pass, and the new value is computed and written back in the second. When an operation reads a record that was written at the same clock edge, the just-written value is passed straight to it. Packets can therefore arrive every cycle, even all to one class, and no update is lost.

Software reads one field of one record per request. A request may also clear that record back to its empty state. Packets always take precedence over software reads.

Top module: `pkt_stat_engine`

## Requirements
- R1: After reset every field of every record reads as zero, and `rd_valid` is low until a read is granted.
- R2: Each packet raises its record's count by one. The count holds at its all-ones maximum and does not wrap.
- R3: Each packet adds its length to its record's byte total. The total holds at its all-ones maximum when the sum would overflow.
- R4: The first packet of an empty record (count zero) sets both the minimum and the maximum length to its own length. Later packets lower the minimum or raise the maximum only when their length lies outside the current range.
- R5: The last-arrival field always holds the timestamp of the most recent packet of that record.
- R6: A packet on a non-empty record adds its timestamp minus the stored last-arrival time to the gap sum. A packet whose timestamp is earlier than the stored one adds zero. The first packet of a record adds nothing. The gap sum saturates at all-ones.
- R7: Packets to the same record on consecutive cycles, or interleaved across records, are all counted. Reads return the same values as with spaced traffic.
- R8: A granted read returns on `rd_data`, zero-extended, the field chosen by `rd_field`: 0 count, 1 byte total, 2 minimum length, 3 maximum length, 4 last arrival, 5 gap sum; codes 6 and 7 return zero. `rd_valid` pulses for one cycle, two clock edges after the grant.
- R9: A granted read with `rd_clear` high returns the value before the clear and then leaves every field of that record at zero. Other records are not changed.
- R10: `rd_grant` equals `rd_req` while `pkt_valid` is low and is low while `pkt_valid` is high. A request that is not granted produces no `rd_valid` and changes no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet update present this cycle |
| pkt_ctx | input | CTX_W | Class index of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_ts | input | TS_W | Arrival timestamp |
| rd_req | input | 1 | Software read request |
| rd_ctx | input | CTX_W | Record to read |
| rd_field | input | 3 | Field code |
| rd_clear | input | 1 | Clear the record after reading it |
| rd_grant | output | 1 | Read request accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | RD_W | Read data, zero-extended |

## Verification
A wrong record value stays in RAM and shows up only when software reads that record, so the bench reads every field of every touched record after each traffic pattern. A broken bypass path shows within one read after a back-to-back burst, as a count lower than the number of packets sent. A wrong saturation or first-packet rule shows as a field that wrapped to a small value or a nonzero gap sum after a single packet. A latency or priority fault shows at once on `rd_valid` two edges after the request.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
  typedef enum logic [2:0] {
    FLD_COUNT  = 3'd0,
    FLD_BYTES  = 3'd1,
    FLD_MINLEN = 3'd2,
    FLD_MAXLEN = 3'd3,
    FLD_LASTTS = 3'd4,
    FLD_GAPSUM = 3'd5
  } stat_field_e;
endpackage

// File: rtl/pkt_stat_store.sv
// Record RAM with per-entry live flags; a non-live entry reads as zero.
module pkt_stat_store #(
  parameter int NUM_CTX = 256,
  parameter int REC_W   = 240,
  localparam int CTX_W  = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [CTX_W-1:0] rd_addr,
  output logic [REC_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_addr,
  input  logic [REC_W-1:0] wr_data,
  input  logic             wr_keep
);
  logic [REC_W-1:0]   mem [NUM_CTX];
  logic [NUM_CTX-1:0] live_q, live_d;
  logic [REC_W-1:0]   rd_q;
  logic               rd_live_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    live_d = live_q;
    if (wr_en) live_d[wr_addr] = wr_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= '0;
      rd_q      <= '0;
      rd_live_q <= 1'b0;
    end else begin
      live_q <= live_d;
      if (rd_en) begin
        rd_q      <= mem[rd_addr];
        rd_live_q <= live_q[rd_addr];
      end
    end
  end

  assign rd_data = rd_live_q ? rd_q : '0;
endmodule

// File: rtl/pkt_stat_update.sv
// Combinational record update for one packet.
module pkt_stat_update #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48,
  parameter int TS_W  = 64,
  parameter int GAP_W = 64,
  localparam int O_BS  = CNT_W,
  localparam int O_MIN = O_BS + SUM_W,
  localparam int O_MAX = O_MIN + LEN_W,
  localparam int O_TS  = O_MAX + LEN_W,
  localparam int O_GAP = O_TS + TS_W,
  localparam int REC_W = O_GAP + GAP_W
) (
  input  logic [REC_W-1:0] old_rec,
  input  logic [LEN_W-1:0] len,
  input  logic [TS_W-1:0]  ts,
  output logic [REC_W-1:0] new_rec
);
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [SUM_W-1:0] bsum, bsum_n;
  logic [SUM_W:0]   bsum_wide;
  logic [LEN_W-1:0] minl, maxl, minl_n, maxl_n;
  logic [TS_W-1:0]  lts, gap;
  logic [GAP_W-1:0] gsum, gsum_n;
  logic [GAP_W:0]   gsum_wide;
  logic             first;

  always_comb begin
    cnt  = old_rec[0     +: CNT_W];
    bsum = old_rec[O_BS  +: SUM_W];
    minl = old_rec[O_MIN +: LEN_W];
    maxl = old_rec[O_MAX +: LEN_W];
    lts  = old_rec[O_TS  +: TS_W];
    gsum = old_rec[O_GAP +: GAP_W];
    first = (cnt == '0);

    cnt_n = (&cnt) ? cnt : cnt + 1'b1;

    bsum_wide = {1'b0, bsum} + {1'b0, SUM_W'(len)};
    bsum_n    = bsum_wide[SUM_W] ? '1 : bsum_wide[SUM_W-1:0];

    minl_n = (first || (len < minl)) ? len : minl;
    maxl_n = (first || (len > maxl)) ? len : maxl;

    gap       = (!first && (ts >= lts)) ? (ts - lts) : '0;
    gsum_wide = {1'b0, gsum} + {1'b0, GAP_W'(gap)};
    gsum_n    = gsum_wide[GAP_W] ? '1 : gsum_wide[GAP_W-1:0];

    new_rec = {gsum_n, ts, maxl_n, minl_n, bsum_n, cnt_n};
  end
endmodule

// File: rtl/pkt_stat_fieldsel.sv
// Selects one record field for the software read port.
module pkt_stat_fieldsel
  import pkt_stat_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48,
  parameter int TS_W  = 64,
  parameter int GAP_W = 64,
  parameter int RD_W  = 64,
  localparam int O_BS  = CNT_W,
  localparam int O_MIN = O_BS + SUM_W,
  localparam int O_MAX = O_MIN + LEN_W,
  localparam int O_TS  = O_MAX + LEN_W,
  localparam int O_GAP = O_TS + TS_W,
  localparam int REC_W = O_GAP + GAP_W
) (
  input  logic [REC_W-1:0] rec,
  input  logic [2:0]       fld,
  output logic [RD_W-1:0]  data
);
  always_comb begin
    unique case (fld)
      FLD_COUNT:  data = RD_W'(rec[0     +: CNT_W]);
      FLD_BYTES:  data = RD_W'(rec[O_BS  +: SUM_W]);
      FLD_MINLEN: data = RD_W'(rec[O_MIN +: LEN_W]);
      FLD_MAXLEN: data = RD_W'(rec[O_MAX +: LEN_W]);
      FLD_LASTTS: data = RD_W'(rec[O_TS  +: TS_W]);
      FLD_GAPSUM: data = RD_W'(rec[O_GAP +: GAP_W]);
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/pkt_stat_engine.sv
module pkt_stat_engine #(
  parameter int NUM_CTX = 256,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int SUM_W   = 48,
  parameter int TS_W    = 64,
  parameter int GAP_W   = 64,
  parameter int RD_W    = 64,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int O_BS   = CNT_W,
  localparam int O_MIN  = O_BS + SUM_W,
  localparam int O_GAP  = O_MIN + 2*LEN_W + TS_W,
  localparam int REC_W  = O_GAP + GAP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [CTX_W-1:0] pkt_ctx,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [TS_W-1:0]  pkt_ts,
  input  logic             rd_req,
  input  logic [CTX_W-1:0] rd_ctx,
  input  logic [2:0]       rd_field,
  input  logic             rd_clear,
  output logic             rd_grant,
  output logic             rd_valid,
  output logic [RD_W-1:0]  rd_data
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  // stage 0: arbitration, packets first
  logic             op_go;
  logic [CTX_W-1:0] op_ctx;
  assign rd_grant = rd_req & ~pkt_valid;
  assign op_go    = pkt_valid | rd_grant;
  assign op_ctx   = pkt_valid ? pkt_ctx : rd_ctx;

  // stage 1 registers
  logic             s1_pkt_q, s1_rd_q, s1_clr_q;
  logic [CTX_W-1:0] s1_ctx_q;
  logic [LEN_W-1:0] s1_len_q;
  logic [TS_W-1:0]  s1_ts_q;
  logic [2:0]       s1_fld_q;
  logic             s1_pkt_d, s1_rd_d, s1_clr_d;
  logic [CTX_W-1:0] s1_ctx_d;
  logic [LEN_W-1:0] s1_len_d;
  logic [TS_W-1:0]  s1_ts_d;
  logic [2:0]       s1_fld_d;

  always_comb begin
    s1_pkt_d = pkt_valid;
    s1_rd_d  = rd_grant;
    s1_clr_d = s1_clr_q;
    s1_ctx_d = s1_ctx_q;
    s1_len_d = s1_len_q;
    s1_ts_d  = s1_ts_q;
    s1_fld_d = s1_fld_q;
    if (op_go) s1_ctx_d = op_ctx;
    if (pkt_valid) begin
      s1_len_d = pkt_len;
      s1_ts_d  = pkt_ts;
    end
    if (rd_grant) begin
      s1_fld_d = rd_field;
      s1_clr_d = rd_clear;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      s1_pkt_q <= 1'b0;
      s1_rd_q  <= 1'b0;
      s1_clr_q <= 1'b0;
      s1_ctx_q <= '0;
      s1_len_q <= '0;
      s1_ts_q  <= '0;
      s1_fld_q <= '0;
    end else begin
      s1_pkt_q <= s1_pkt_d;
      s1_rd_q  <= s1_rd_d;
      s1_clr_q <= s1_clr_d;
      s1_ctx_q <= s1_ctx_d;
      s1_len_q <= s1_len_d;
      s1_ts_q  <= s1_ts_d;
      s1_fld_q <= s1_fld_d;
    end
  end

  // record store
  logic             wr_en, wr_keep;
  logic [REC_W-1:0] wr_data, store_rec;

  pkt_stat_store #(.NUM_CTX(NUM_CTX), .REC_W(REC_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_ns),
    .rd_en   (op_go),
    .rd_addr (op_ctx),
    .rd_data (store_rec),
    .wr_en   (wr_en),
    .wr_addr (s1_ctx_q),
    .wr_data (wr_data),
    .wr_keep (wr_keep)
  );

  // bypass of the write made at the same edge as the RAM read
  logic             wb_valid_q, wb_keep_q;
  logic [CTX_W-1:0] wb_ctx_q;
  logic [REC_W-1:0] wb_rec_q;
  logic [REC_W-1:0] cur_rec;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wb_valid_q <= 1'b0;
      wb_keep_q  <= 1'b0;
      wb_ctx_q   <= '0;
      wb_rec_q   <= '0;
    end else begin
      wb_valid_q <= wr_en;
      if (wr_en) begin
        wb_keep_q <= wr_keep;
        wb_ctx_q  <= s1_ctx_q;
        wb_rec_q  <= wr_data;
      end
    end
  end

  always_comb begin
    cur_rec = store_rec;
    if (wb_valid_q && (wb_ctx_q == s1_ctx_q))
      cur_rec = wb_keep_q ? wb_rec_q : '0;
  end

  // stage 1 compute
  logic [REC_W-1:0] upd_rec;
  logic [RD_W-1:0]  sel_data;

  pkt_stat_update #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .TS_W(TS_W), .GAP_W(GAP_W)
  ) u_update (
    .old_rec (cur_rec),
    .len     (s1_len_q),
    .ts      (s1_ts_q),
    .new_rec (upd_rec)
  );

  pkt_stat_fieldsel #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .TS_W(TS_W), .GAP_W(GAP_W),
    .RD_W(RD_W)
  ) u_fieldsel (
    .rec  (cur_rec),
    .fld  (s1_fld_q),
    .data (sel_data)
  );

  assign wr_en   = s1_pkt_q | (s1_rd_q & s1_clr_q);
  assign wr_keep = s1_pkt_q;
  assign wr_data = s1_pkt_q ? upd_rec : '0;

  // read return register
  logic             rd_valid_q;
  logic [RD_W-1:0]  rd_data_q, rd_data_d;
  assign rd_data_d = s1_rd_q ? sel_data : rd_data_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= s1_rd_q;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/pkt_stat_engine_chk.sv
module pkt_stat_engine_chk #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48,
  parameter int GAP_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             rd_grant,
  input logic             rd_valid,
  input logic             upd_en,
  input logic [CNT_W-1:0] old_cnt,
  input logic [CNT_W-1:0] new_cnt,
  input logic [SUM_W-1:0] old_bytes,
  input logic [SUM_W-1:0] new_bytes,
  input logic [LEN_W-1:0] new_min,
  input logic [LEN_W-1:0] new_max,
  input logic [GAP_W-1:0] new_gap
);
  p_grant_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !rd_grant);

  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_grant, 2));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((new_cnt == old_cnt + 1'b1) || ((&old_cnt) && (&new_cnt))));

  p_bytes_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (new_bytes >= old_bytes));

  p_min_le_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (new_min <= new_max));

  p_first_nogap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (old_cnt == '0)) |-> (new_gap == '0));
endmodule

bind pkt_stat_engine pkt_stat_engine_chk #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .GAP_W(GAP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .pkt_valid (pkt_valid),
  .rd_grant  (rd_grant),
  .rd_valid  (rd_valid),
  .upd_en    (s1_pkt_q),
  .old_cnt   (cur_rec[CNT_W-1:0]),
  .new_cnt   (upd_rec[CNT_W-1:0]),
  .old_bytes (cur_rec[O_BS +: SUM_W]),
  .new_bytes (upd_rec[O_BS +: SUM_W]),
  .new_min   (upd_rec[O_MIN +: LEN_W]),
  .new_max   (upd_rec[O_MIN + LEN_W +: LEN_W]),
  .new_gap   (upd_rec[O_GAP +: GAP_W])
);

// File: tb/pkt_stat_engine_tb.sv
module pkt_stat_engine_tb;
  localparam int NC = 8, LW = 8, CW = 8, SW = 12, TW = 16, GW = 16, RW = 16;
  localparam int CNT_MAX = (1 << CW) - 1;
  localparam int SUM_MAX = (1 << SW) - 1;
  localparam int GAP_MAX = (1 << GW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_valid = 1'b0;
  logic [2:0]    pkt_ctx = '0;
  logic [LW-1:0] pkt_len = '0;
  logic [TW-1:0] pkt_ts = '0;
  logic          rd_req = 1'b0;
  logic [2:0]    rd_ctx = '0;
  logic [2:0]    rd_field = '0;
  logic          rd_clear = 1'b0;
  logic          rd_grant, rd_valid;
  logic [RW-1:0] rd_data;

  always #5 clk = ~clk;

  pkt_stat_engine #(
    .NUM_CTX(NC), .LEN_W(LW), .CNT_W(CW), .SUM_W(SW), .TS_W(TW), .GAP_W(GW), .RD_W(RW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ctx(pkt_ctx),
    .pkt_len(pkt_len), .pkt_ts(pkt_ts), .rd_req(rd_req), .rd_ctx(rd_ctx),
    .rd_field(rd_field), .rd_clear(rd_clear), .rd_grant(rd_grant),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_cnt[NC], m_bytes[NC], m_min[NC], m_max[NC], m_ts[NC], m_gap[NC];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_field(input int c, input int f);
    case (f)
      0: return m_cnt[c];
      1: return m_bytes[c];
      2: return m_min[c];
      3: return m_max[c];
      4: return m_ts[c];
      5: return m_gap[c];
      default: return 0;
    endcase
  endfunction

  function automatic void model_clear(input int c);
    m_cnt[c] = 0; m_bytes[c] = 0; m_min[c] = 0;
    m_max[c] = 0; m_ts[c] = 0; m_gap[c] = 0;
  endfunction

  // one packet this cycle; back-to-back calls give consecutive cycles
  task automatic send_pkt(input int c, input int len, input int ts);
    int g;
    pkt_valid = 1'b1; pkt_ctx = 3'(c); pkt_len = LW'(len); pkt_ts = TW'(ts);
    if (m_cnt[c] == 0) begin
      m_min[c] = len; m_max[c] = len;
    end else begin
      g = (ts >= m_ts[c]) ? ts - m_ts[c] : 0;
      m_gap[c] = (m_gap[c] + g > GAP_MAX) ? GAP_MAX : m_gap[c] + g;
      if (len < m_min[c]) m_min[c] = len;
      if (len > m_max[c]) m_max[c] = len;
    end
    if (m_cnt[c] < CNT_MAX) m_cnt[c]++;
    m_bytes[c] = (m_bytes[c] + len > SUM_MAX) ? SUM_MAX : m_bytes[c] + len;
    m_ts[c] = ts;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // granted read; result sampled two edges after the request
  task automatic do_read(input int c, input int f, input bit clr, input string req);
    int exp;
    exp = model_field(c, f);
    rd_req = 1'b1; rd_ctx = 3'(c); rd_field = 3'(f); rd_clear = clr;
    @(negedge clk);
    rd_req = 1'b0; rd_clear = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
    check(int'(rd_data) == exp, req, int'(rd_data), exp);
    if (clr) model_clear(c);
  endtask

  task automatic read_all(input int c, input string req);
    for (int f = 0; f < 6; f++) do_read(c, f, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ts;
    for (int c = 0; c < NC; c++) model_clear(c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rd_valid == 1'b0, "R1 rd_valid idle", int'(rd_valid), 0);
    for (int c = 0; c < NC; c++) read_all(c, "R1 reset zero");

    // R2 R3 R4 R5 R6: spaced packets over every record, then R8 field reads
    ts = 100;
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 5; k++) begin
        ts = ts + 7 + c * 3 + k;
        send_pkt(c, 20 + ((c * 37 + k * 53) % 200), ts);
        @(negedge clk);
      end
    end
    for (int c = 0; c < NC; c++) read_all(c, "R2 R3 R4 R5 R6 R8 spaced");

    // R7: same record on consecutive cycles
    for (int k = 0; k < 12; k++) begin
      ts = ts + 5;
      send_pkt(2, 60 + k * 9, ts);
    end
    read_all(2, "R7 burst same record");

    // R7: interleaved records, read directly after the last packet
    for (int k = 0; k < 10; k++) begin
      ts = ts + 3;
      send_pkt(k % 2, 10 + k * 11, ts);
    end
    read_all(0, "R7 interleaved");
    read_all(1, "R7 interleaved");

    // R6: earlier timestamp adds zero gap
    send_pkt(3, 40, 50);
    do_read(3, 5, 1'b0, "R6 backward ts");
    do_read(3, 4, 1'b0, "R5 backward ts last");

    // R8: unused field codes read zero
    do_read(4, 6, 1'b0, "R8 code6");
    do_read(4, 7, 1'b0, "R8 code7");

    // R9: clear-on-read returns old value, then record is empty
    do_read(4, 0, 1'b1, "R9 clear returns old");
    read_all(4, "R9 after clear");
    read_all(5, "R9 neighbour kept");
    send_pkt(4, 77, 9000);
    read_all(4, "R9 R4 first after clear");

    // R9: clear issued right after a packet to the same record
    send_pkt(7, 33, 9500);
    do_read(7, 0, 1'b1, "R9 clear after packet");
    read_all(7, "R9 cleared after packet");

    // R10: packet beats read request
    rd_req = 1'b1; rd_ctx = 3'd6; rd_field = 3'd0; rd_clear = 1'b1;
    pkt_valid = 1'b1; pkt_ctx = 3'd6; pkt_len = 8'd9; pkt_ts = 16'd9600;
    #1;
    check(rd_grant == 1'b0, "R10 grant blocked", int'(rd_grant), 0);
    if (m_cnt[6] < CNT_MAX) m_cnt[6]++;
    m_gap[6] = m_gap[6] + ((9600 >= m_ts[6]) ? 9600 - m_ts[6] : 0);
    if (m_gap[6] > GAP_MAX) m_gap[6] = GAP_MAX;
    m_bytes[6] = (m_bytes[6] + 9 > SUM_MAX) ? SUM_MAX : m_bytes[6] + 9;
    if (9 < m_min[6]) m_min[6] = 9;
    if (9 > m_max[6]) m_max[6] = 9;
    m_ts[6] = 9600;
    @(negedge clk);
    pkt_valid = 1'b0; rd_req = 1'b0; rd_clear = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R10 no rd_valid", int'(rd_valid), 0);
    read_all(6, "R10 record not cleared");

    // R2 R3: saturation of count and byte total
    for (int k = 0; k < 300; k++) send_pkt(5, 200, 10000 + k * 100);
    do_read(5, 0, 1'b0, "R2 count saturates");
    do_read(5, 1, 1'b0, "R3 bytes saturate");
    read_all(5, "R2 R3 saturated record");

    // R6: gap sum saturation
    do_read(1, 0, 1'b1, "R9 clear for gap test");
    send_pkt(1, 5, 0);
    send_pkt(1, 5, 40000);
    send_pkt(1, 5, 65000);
    send_pkt(1, 5, 0);
    send_pkt(1, 5, 30000);
    do_read(1, 5, 1'b0, "R6 gap saturates");
    check(m_gap[1] == GAP_MAX, "R6 model saturation", m_gap[1], GAP_MAX);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule